// File: doc/BRIEF.md
# Multi-Pack Cartridge Detector and Bank Sequencer

This block decides whether a cartridge is a two-bank multi-pack by probing four header bytes. It works through a byte-wide request port to a bus master and holds the result on its outputs: the multi-pack flag, the two bank-select values read from the cartridge, the total image size, and a warning for a bank pair it does not recognise. A single-pack cartridge takes its size from the `single_size` input, which a separate mirror-size detector supplies.

During a dump, the sequencer hands the consumer one or two address windows, called phases. The consumer reads each window and acknowledges it. On a multi-pack cartridge, the sequencer writes the matching bank value into the cartridge's bank register before each half is read, and it restores bank 0 at the end. Each bank write targets the CPU internal area. The bus master must hold write-enable low for about 730 ns on such a write. The bus master performs the actual read and write cycles. It answers each request with a single-cycle `req_done` pulse, and on a read `rsp_data` is valid in that same cycle.

Top module: `cart_bank_seq`

## Requirements
- R1: After reset, `multipack`, `bank0`, `bank1`, `size`, `size_warn`, `busy`, `req_valid` and `phase_valid` are all zero.
- R2: A detect pulse issues ROM-area reads (`req_write`=0, `req_internal`=0) in this order: 0x3FFC, 0x3FFD, 0x3FFB, 0x3FFF. The sequence stops early at the first of these conditions: a zero at 0x3FFC, a zero at 0x3FFD, or a nonzero value at 0x3FFB or 0x3FFF.
- R3: `multipack` is set only when 0x3FFC and 0x3FFD are both nonzero and 0x3FFB and 0x3FFF are both zero. `bank0` takes the nonzero byte at 0x3FFC. `bank1` takes the nonzero byte at 0x3FFD. Both are cleared when detection starts.
- R4: On a multi-pack cartridge, `size` depends on the bank pair (bank0/bank1). The pair 0x28/0x2E gives 0x200000 and the pair 0x20/0x31 gives 0x400000. Any other pair gives 0x400000 and raises `size_warn`. On a single-pack cartridge, `size` takes `single_size` and `size_warn` is 0.
- R5: A multi-pack dump runs these steps in order. It writes `bank0` to address 0xFFFF in the internal area (`req_internal`=1). It offers a phase with base 0 and length size/2. It writes `bank1` to 0xFFFF. It offers a phase with base 0x200000 and length size/2. It writes `bank0` to 0xFFFF again.
- R6: A single-pack dump offers exactly one phase, with base 0 and length `size`, and issues no bus request.
- R7: A phase is offered only after the `req_done` of the bank write before it. It stays asserted, with stable base and length, until `phase_ack`.
- R8: A request stays asserted, with stable address, direction and write data, until `req_done`.
- R9: `start_detect` and `start_dump` are ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_detect | input | 1 | Pulse: probe the header |
| start_dump | input | 1 | Pulse: run the dump phase sequence |
| single_size | input | 23 | Image size to use for a single-pack cartridge |
| req_valid | output | 1 | Bus request pending |
| req_write | output | 1 | 1 = write, 0 = read |
| req_internal | output | 1 | 1 = CPU internal area, 0 = ROM area |
| req_addr | output | 22 | Request address |
| req_wdata | output | 8 | Write data |
| req_done | input | 1 | Single-cycle completion of the pending request |
| rsp_data | input | 8 | Read data, valid with `req_done` |
| phase_valid | output | 1 | A dump window is offered |
| phase_base | output | 22 | Window start address |
| phase_len | output | 23 | Window length in bytes |
| phase_ack | input | 1 | Consumer finished the window |
| multipack | output | 1 | Cartridge is a two-bank multi-pack |
| bank0 | output | 8 | Bank-0 select value |
| bank1 | output | 8 | Bank-1 select value |
| size | output | 23 | Total image size in bytes |
| size_warn | output | 1 | Bank pair not recognised, 4 MB assumed |
| busy | output | 1 | Detection or dump in progress |

## Verification
The assertions check on every cycle that requests and phases hold steady until their handshakes, and that every write goes to the bank register. They also check that the warning only accompanies a 4 MB multi-pack result, and that a single-pack phase spans base 0 and the full size. Other behaviour shows only in the bench's scenarios, because it concerns order and content over a whole operation. That covers the early stop of the header probe at each of its four reads, the mapping from bank pairs to sizes, and the order of bank writes and phases with the values written. It also covers the rejection of start pulses during an operation.

// File: rtl/cart_bank_seq.sv
module cart_bank_seq #(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 8,
  parameter int SIZE_W = 23,
  parameter logic [ADDR_W-1:0] SEL0_ADDR = 22'h3FFC,
  parameter logic [ADDR_W-1:0] SEL1_ADDR = 22'h3FFD,
  parameter logic [ADDR_W-1:0] PAD0_ADDR = 22'h3FFB,
  parameter logic [ADDR_W-1:0] PAD1_ADDR = 22'h3FFF,
  parameter logic [ADDR_W-1:0] BANK_REG_ADDR = 22'h00FFFF,
  parameter logic [ADDR_W-1:0] UPPER_BASE = 22'h200000,
  parameter logic [DATA_W-1:0] SMALL_B0 = 8'h28,
  parameter logic [DATA_W-1:0] SMALL_B1 = 8'h2E,
  parameter logic [DATA_W-1:0] LARGE_B0 = 8'h20,
  parameter logic [DATA_W-1:0] LARGE_B1 = 8'h31,
  parameter logic [SIZE_W-1:0] SMALL_SIZE = 23'h200000,
  parameter logic [SIZE_W-1:0] LARGE_SIZE = 23'h400000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_detect,
  input  logic              start_dump,
  input  logic [SIZE_W-1:0] single_size,
  output logic              req_valid,
  output logic              req_write,
  output logic              req_internal,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_wdata,
  input  logic              req_done,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              phase_valid,
  output logic [ADDR_W-1:0] phase_base,
  output logic [SIZE_W-1:0] phase_len,
  input  logic              phase_ack,
  output logic              multipack,
  output logic [DATA_W-1:0] bank0,
  output logic [DATA_W-1:0] bank1,
  output logic [SIZE_W-1:0] size,
  output logic              size_warn,
  output logic              busy
);

  typedef enum logic [1:0] {S_IDLE, S_READ, S_BANK, S_PHASE} state_t;

  localparam logic [2:0] STEP_UPPER = 3'd3;
  localparam logic [2:0] STEP_LAST  = 3'd4;
  localparam logic [2:0] STEP_SEL1  = 3'd2;

  state_t      st;
  logic [1:0]  rd_idx;
  logic [2:0]  step;
  logic        rsp_zero;
  logic [ADDR_W-1:0] hdr_addr;

  assign rsp_zero = (rsp_data == '0);

  always_comb begin
    case (rd_idx)
      2'd0:    hdr_addr = SEL0_ADDR;
      2'd1:    hdr_addr = SEL1_ADDR;
      2'd2:    hdr_addr = PAD0_ADDR;
      default: hdr_addr = PAD1_ADDR;
    endcase
  end

  assign busy         = (st != S_IDLE);
  assign req_valid    = (st == S_READ) || (st == S_BANK);
  assign req_write    = (st == S_BANK);
  assign req_internal = (st == S_BANK);
  assign req_addr     = (st == S_BANK) ? BANK_REG_ADDR : hdr_addr;
  assign req_wdata    = (st != S_BANK) ? '0 : ((step == STEP_SEL1) ? bank1 : bank0);
  assign phase_valid  = (st == S_PHASE);
  assign phase_base   = (multipack && step == STEP_UPPER) ? UPPER_BASE : '0;
  assign phase_len    = multipack ? (size >> 1) : size;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      rd_idx    <= '0;
      step      <= '0;
      multipack <= 1'b0;
      bank0     <= '0;
      bank1     <= '0;
      size      <= '0;
      size_warn <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          if (start_detect) begin
            st        <= S_READ;
            rd_idx    <= '0;
            multipack <= 1'b0;
            bank0     <= '0;
            bank1     <= '0;
            size_warn <= 1'b0;
          end else if (start_dump) begin
            step <= '0;
            st   <= multipack ? S_BANK : S_PHASE;
          end
        end
        S_READ: begin
          if (req_done) begin
            case (rd_idx)
              2'd0: begin
                if (rsp_zero) begin
                  size <= single_size;
                  st   <= S_IDLE;
                end else begin
                  bank0  <= rsp_data;
                  rd_idx <= 2'd1;
                end
              end
              2'd1: begin
                if (rsp_zero) begin
                  size <= single_size;
                  st   <= S_IDLE;
                end else begin
                  bank1  <= rsp_data;
                  rd_idx <= 2'd2;
                end
              end
              2'd2: begin
                if (!rsp_zero) begin
                  size <= single_size;
                  st   <= S_IDLE;
                end else begin
                  rd_idx <= 2'd3;
                end
              end
              default: begin
                st <= S_IDLE;
                if (!rsp_zero) begin
                  size <= single_size;
                end else begin
                  multipack <= 1'b1;
                  if (bank0 == SMALL_B0 && bank1 == SMALL_B1) begin
                    size <= SMALL_SIZE;
                  end else if (bank0 == LARGE_B0 && bank1 == LARGE_B1) begin
                    size <= LARGE_SIZE;
                  end else begin
                    size      <= LARGE_SIZE;
                    size_warn <= 1'b1;
                  end
                end
              end
            endcase
          end
        end
        S_BANK: begin
          if (req_done) begin
            if (step == STEP_LAST) begin
              st <= S_IDLE;
            end else begin
              st   <= S_PHASE;
              step <= step + 3'd1;
            end
          end
        end
        default: begin
          if (phase_ack) begin
            if (!multipack) begin
              st <= S_IDLE;
            end else begin
              st   <= S_BANK;
              step <= step + 3'd1;
            end
          end
        end
      endcase
    end
  end

  a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_done |=> req_valid && $stable(req_addr) && $stable(req_write) && $stable(req_wdata));

  a_r7_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
    phase_valid && !phase_ack |=> phase_valid && $stable(phase_base) && $stable(phase_len));

  a_r5_write_target: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_write |-> req_addr == BANK_REG_ADDR && req_internal);

  a_r4_warn_large: assert property (@(posedge clk) disable iff (!rst_n)
    size_warn |-> multipack && size == LARGE_SIZE);

  a_r3_banks_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    multipack |-> bank0 != '0 && bank1 != '0);

  a_r6_single_window: assert property (@(posedge clk) disable iff (!rst_n)
    phase_valid && !multipack |-> phase_base == '0 && phase_len == size);

  a_r5_upper_multi: assert property (@(posedge clk) disable iff (!rst_n)
    phase_valid && phase_base != '0 |-> multipack && phase_base == UPPER_BASE);

endmodule

// File: tb/cart_bank_seq_tb.sv
`timescale 1ns/1ps
module cart_bank_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_detect = 1'b0;
  logic        start_dump = 1'b0;
  logic [22:0] single_size = '0;
  logic        req_valid, req_write, req_internal;
  logic [21:0] req_addr;
  logic [7:0]  req_wdata;
  logic        req_done = 1'b0;
  logic [7:0]  rsp_data = '0;
  logic        phase_valid;
  logic [21:0] phase_base;
  logic [22:0] phase_len;
  logic        phase_ack = 1'b0;
  logic        multipack, size_warn, busy;
  logic [7:0]  bank0, bank1;
  logic [22:0] size;

  always #2 clk = ~clk;

  cart_bank_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start_detect(start_detect), .start_dump(start_dump),
    .single_size(single_size), .req_valid(req_valid), .req_write(req_write),
    .req_internal(req_internal), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_done(req_done), .rsp_data(rsp_data), .phase_valid(phase_valid),
    .phase_base(phase_base), .phase_len(phase_len), .phase_ack(phase_ack),
    .multipack(multipack), .bank0(bank0), .bank1(bank1), .size(size),
    .size_warn(size_warn), .busy(busy)
  );

  // {pad0@3FFB, sel0@3FFC, sel1@3FFD, pad1@3FFF, single_size, exp_multi, exp_size, exp_warn, exp_reads}
  localparam int NV = 8;
  localparam logic [82:0] VEC [NV] = '{
    {8'h00, 8'h00, 8'h55, 8'h00, 23'h100000, 1'b0, 23'h100000, 1'b0, 3'd1},
    {8'h00, 8'h28, 8'h00, 8'h00, 23'h200000, 1'b0, 23'h200000, 1'b0, 3'd2},
    {8'h01, 8'h28, 8'h2E, 8'h00, 23'h400000, 1'b0, 23'h400000, 1'b0, 3'd3},
    {8'h00, 8'h28, 8'h2E, 8'h07, 23'h100000, 1'b0, 23'h100000, 1'b0, 3'd4},
    {8'h00, 8'h28, 8'h2E, 8'h00, 23'h100000, 1'b1, 23'h200000, 1'b0, 3'd4},
    {8'h00, 8'h20, 8'h31, 8'h00, 23'h100000, 1'b1, 23'h400000, 1'b0, 3'd4},
    {8'h00, 8'h2E, 8'h28, 8'h00, 23'h100000, 1'b1, 23'h400000, 1'b1, 3'd4},
    {8'h00, 8'h33, 8'h44, 8'h00, 23'h100000, 1'b1, 23'h400000, 1'b1, 3'd4}
  };

  int tests = 0;
  int fails = 0;
  logic [7:0] m_pad0, m_sel0, m_sel1, m_pad1;
  int lat = 0;
  int n_req = 0;
  int n_ph = 0;
  logic [21:0] l_addr [16];
  logic        l_wr   [16];
  logic        l_int  [16];
  logic [7:0]  l_wd   [16];
  logic [21:0] p_base [4];
  logic [22:0] p_len  [4];
  int          p_reqs [4];

  function automatic logic [7:0] hdr(input logic [21:0] a);
    case (a)
      22'h3FFB: return m_pad0;
      22'h3FFC: return m_sel0;
      22'h3FFD: return m_sel1;
      22'h3FFF: return m_pad1;
      default:  return 8'h00;
    endcase
  endfunction

  // bus master model with latency lat (R8: request must persist through the wait)
  initial begin
    int w;
    w = 0;
    forever begin
      @(negedge clk);
      if (req_done) begin
        req_done = 1'b0;
        w = 0;
      end else if (req_valid) begin
        if (w >= lat) begin
          req_done = 1'b1;
          rsp_data = req_write ? 8'h00 : hdr(req_addr);
          if (n_req < 16) begin
            l_addr[n_req] = req_addr; l_wr[n_req] = req_write;
            l_int[n_req] = req_internal; l_wd[n_req] = req_wdata;
          end
          n_req++;
        end else w++;
      end
    end
  end

  initial begin
    int w;
    w = 0;
    forever begin
      @(negedge clk);
      if (phase_ack) begin
        phase_ack = 1'b0;
        w = 0;
      end else if (phase_valid) begin
        if (w >= lat + 1) begin
          phase_ack = 1'b1;
          if (n_ph < 4) begin
            p_base[n_ph] = phase_base; p_len[n_ph] = phase_len; p_reqs[n_ph] = n_req;
          end
          n_ph++;
        end else w++;
      end
    end
  end

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic pulse_detect();
    @(negedge clk); start_detect = 1'b1;
    @(negedge clk); start_detect = 1'b0;
  endtask

  task automatic pulse_dump();
    @(negedge clk); start_dump = 1'b1;
    @(negedge clk); start_dump = 1'b0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      if (!busy) break;
    end
  endtask

  task automatic clear_logs();
    n_req = 0; n_ph = 0;
  endtask

  task automatic check_multi_dump(input logic [7:0] b0, input logic [7:0] b1, input logic [22:0] sz);
    check(n_req == 3, "R5", "bank write count", n_req, 3);
    for (int k = 0; k < 3; k++) begin
      check(l_wr[k] && l_int[k] && l_addr[k] == 22'h00FFFF, "R5", "bank write target", l_addr[k], 22'h00FFFF);
      check(l_wd[k] == ((k == 1) ? b1 : b0), "R5", "bank write value", l_wd[k], (k == 1) ? b1 : b0);
    end
    check(n_ph == 2, "R5", "phase count", n_ph, 2);
    check(p_base[0] == 22'h0 && p_len[0] == (sz >> 1), "R5", "lower phase len", p_len[0], sz >> 1);
    check(p_base[1] == 22'h200000 && p_len[1] == (sz >> 1), "R5", "upper phase base", p_base[1], 22'h200000);
    check(p_reqs[0] == 1 && p_reqs[1] == 2, "R7", "writes before phases", p_reqs[1], 2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [21:0] order [4];
    order[0] = 22'h3FFC; order[1] = 22'h3FFD; order[2] = 22'h3FFB; order[3] = 22'h3FFF;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(!multipack && !size_warn && !busy, "R1", "flags after reset", {multipack, size_warn, busy}, 0);
    check(bank0 == 0 && bank1 == 0 && size == 0, "R1", "values after reset", size, 0);
    check(!req_valid && !phase_valid, "R1", "handshakes after reset", {req_valid, phase_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [7:0] e_b1;
      m_pad0 = VEC[i][82:75]; m_sel0 = VEC[i][74:67];
      m_sel1 = VEC[i][66:59]; m_pad1 = VEC[i][58:51];
      single_size = VEC[i][50:28];
      lat = i % 4;
      e_b1 = (m_sel0 != 0) ? m_sel1 : 8'h00;
      clear_logs();
      pulse_detect();
      wait_idle();
      check(n_req == int'(VEC[i][2:0]), "R2", "header read count", n_req, VEC[i][2:0]);
      for (int k = 0; k < 4; k++)
        if (k < n_req)
          check(l_addr[k] == order[k] && !l_wr[k] && !l_int[k], "R2", "header read address", l_addr[k], order[k]);
      check(multipack == VEC[i][27], "R3", "multipack flag", multipack, VEC[i][27]);
      check(bank0 == m_sel0 && bank1 == e_b1, "R3", "bank values", {bank0, bank1}, {m_sel0, e_b1});
      check(size == VEC[i][26:4], "R4", "size", size, VEC[i][26:4]);
      check(size_warn == VEC[i][3], "R4", "size warning", size_warn, VEC[i][3]);

      clear_logs();
      pulse_dump();
      wait_idle();
      if (VEC[i][27]) check_multi_dump(m_sel0, m_sel1, VEC[i][26:4]);
      else begin
        check(n_req == 0, "R6", "no requests single", n_req, 0);
        check(n_ph == 1 && p_base[0] == 0 && p_len[0] == VEC[i][50:28], "R6", "single phase len", p_len[0], VEC[i][50:28]);
      end
    end

    // R9: starts during a dump are ignored (state still bank 0x33/0x44 multi)
    lat = 2;
    clear_logs();
    pulse_dump();
    repeat (2) @(negedge clk);
    m_sel0 = 8'h00;
    pulse_detect();
    pulse_dump();
    wait_idle();
    check_multi_dump(8'h33, 8'h44, 23'h400000);
    check(bank0 == 8'h33 && multipack, "R9", "detect ignored while dumping", bank0, 8'h33);

    // R9: dump pulse during detection is ignored
    m_sel0 = 8'h28; m_sel1 = 8'h2E;
    clear_logs();
    pulse_detect();
    pulse_dump();
    wait_idle();
    check(n_ph == 0, "R9", "dump ignored while detecting", n_ph, 0);
    check(size == 23'h200000 && !size_warn, "R4", "2MB pair redetected", size, 23'h200000);

    // R6 dump before a multi-pack result: single_size taken after zero selector
    m_sel0 = 8'h00; single_size = 23'h080000;
    clear_logs();
    pulse_detect();
    wait_idle();
    clear_logs();
    pulse_dump();
    wait_idle();
    check(n_req == 0 && n_ph == 1 && p_len[0] == 23'h080000, "R6", "single phase after redetect", p_len[0], 23'h080000);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule